// File: doc/BRIEF.md
# SDRAM Row-Keeping Command Sequencer

This block sits between a simple request port and the command pins of up to two SDRAM devices. Each request carries a byte address and a read/write flag. The block splits the address into a device select, an internal bank, a row and a column. The split follows the configured data width and geometry. The block remembers which row is open in every internal bank of both devices. From that record it issues only the commands the access needs: a read or write when the row is already open, an activate first when the bank is idle, or a precharge, activate and access when the bank holds a different row.

Rows stay open after an access. A row is closed only when a later access to the same bank needs another row, or when the host asks for a precharge of all banks. Because the next row or bank is simply the next address, an access that runs off the end of a row or a bank is handled like any other miss. In the largest geometry, running off the last bank of the first device lands in the second device. In every other geometry such an overrun falls outside the device and is refused. Programmable gaps space the precharge-to-activate and activate-to-access commands. A write to a write-protected device, or an address beyond the configured span, is answered with an error and produces no command.

Top module: `row_track_seq`

## Requirements
- R1: The lowest column bit is taken from byte-address bit 0, 1 or 2 when cfgWidth is 0 (8-bit), 1 (16-bit) or 2 (32-bit); lower byte-address bits do not change the column.
- R2: Above the byte offset, the word address holds the column in its lowest 8+cfgColSel bits, then the row in the next 11+cfgRowSel bits, then the bank in the next 1 bit (cfgFourBanks=0) or 2 bits (cfgFourBanks=1). Any set bit above the bank field, within byte-address bits 27:0, is out of range.
- R3: Byte-address bit 28 selects the device (cmdDev). Each device keeps its own open-row record for every bank.
- R4: When the addressed bank already holds the requested row, the read (code 2) or write (code 3) strobe is issued in the first cycle after the request is accepted, together with respValid=1 and respErr=0.
- R5: When the addressed bank holds a different row, a precharge (code 4, cmdAddr 0) for that bank is issued first, then an activate, then the access.
- R6: When the addressed bank holds no open row, an activate (code 1, cmdAddr = row) is issued in the first cycle after acceptance, followed by the access.
- R7: An activate follows its precharge after max(cfgTrp,1) cycles, and the access follows its activate after max(cfgTrcd,1) cycles; no command and no response appear in the cycles between.
- R8: On read and write strobes, cmdAddr[10] is 0, cmdAddr[9:0] carry column bits 9:0, cmdAddr[11] carries column bit 10, and cmdAddr[12] is 0.
- R9: A write to a device whose cfgWrProt bit is set, or an out-of-range address, gives respValid=1 and respErr=1 in the first cycle after acceptance, with no command.
- R10: Sequential addresses that cross a row or bank boundary open the next row or the first row of the next bank. From the last bank the span reaches the second device only with 32-bit width, 13 rows bits, 11 column bits and 4 banks; otherwise the overrun is an error.
- R11: Reset, and a precharge-all request (pallReq), clear the open-row record of both devices. Precharge-all is a strobe with code 5 and cmdAddr[10]=1, and holds reqReady low.
- R12: After reset reqReady is 1 and cmdValid and respValid are 0. reqReady is high only when the block is idle, and every command is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWidth | input | 2 | Data width: 0=8, 1=16, 2=32 bits |
| cfgRowSel | input | 2 | Row bits: 11 + value (0..2) |
| cfgColSel | input | 2 | Column bits: 8 + value (0..3) |
| cfgFourBanks | input | 1 | 1 = four internal banks, 0 = two |
| cfgWrProt | input | 2 | Write-protect bit per device |
| cfgTrp | input | 4 | Precharge-to-activate gap in cycles |
| cfgTrcd | input | 4 | Activate-to-access gap in cycles |
| pallReq | input | 1 | Request a precharge of all banks |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 29 | Byte address; bit 28 selects the device |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| respValid | output | 1 | One-cycle completion pulse |
| respErr | output | 1 | Completion is a bus error |
| cmdValid | output | 1 | Command strobe |
| cmdCode | output | 3 | 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all |
| cmdDev | output | 1 | Target device |
| cmdBank | output | 2 | Target internal bank |
| cmdAddr | output | 13 | Row or column address lines |

## Verification
The bench drives hits, misses against an idle bank and misses against a different open row. The same row number is requested on both devices, where a single shared record would wrongly report a hit. Zero and non-zero gap values are used, so an off-by-one in the wait counter shows up as an activate or access one cycle early or late. Addresses just past the last column and the last row are used to see whether row and bank boundaries decode correctly. The overrun from the last bank of the first device must reach the second device in the largest geometry and be refused in the two-bank geometry. A column with bit 10 set shows any leak of that bit onto the auto-precharge line. An access repeated after precharge-all must activate again rather than hit.

// File: rtl/rts_pkg.sv
package rts_pkg;
  parameter int HADDR_W  = 29;
  parameter int ROW_W    = 13;
  parameter int COL_W    = 11;
  parameter int BANK_MAX = 4;
  parameter int DEV_N    = 2;
  parameter int GAP_W    = 4;
  parameter int AP_BIT   = 10;

  localparam int SPAN_W  = HADDR_W - 1;
  localparam int BANK_W  = $clog2(BANK_MAX);
  localparam int ENTRIES = DEV_N * BANK_MAX;
  localparam int IDX_W   = $clog2(ENTRIES);

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PALL = 3'd5
  } cmd_e;

  typedef struct packed {
    logic latchReq;
    logic markOpen;
    logic markClosed;
    logic clearAll;
  } strobe_t;
endpackage

// File: rtl/rts_datapath.sv
module rts_datapath
  import rts_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgWidth,
  input  logic [1:0]         cfgRowSel,
  input  logic [1:0]         cfgColSel,
  input  logic               cfgFourBanks,
  input  logic [DEV_N-1:0]   cfgWrProt,
  input  strobe_t            strobe,
  input  logic               reqWrite,
  input  logic [HADDR_W-1:0] reqAddr,
  input  cmd_e               cmdCode,
  output logic               hit,
  output logic               bankOpen,
  output logic               reqErr,
  output logic               isWrite,
  output logic               devSel,
  output logic [BANK_W-1:0]  bankSel,
  output logic [ROW_W-1:0]   cmdAddr
);
  logic [SPAN_W-1:0] latAddr;
  logic              latDev;
  logic              latWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr  <= '0;
      latDev   <= 1'b0;
      latWrite <= 1'b0;
    end else if (strobe.latchReq) begin
      latAddr  <= reqAddr[SPAN_W-1:0];
      latDev   <= reqAddr[SPAN_W];
      latWrite <= reqWrite;
    end
  end

  // field split of the latched byte address
  logic [4:0]        colBits, rowBits, bankBits;
  logic [SPAN_W-1:0] wordAddr, upper;
  logic [COL_W-1:0]  colSel;
  logic [ROW_W-1:0]  rowSel;
  logic              badCfg;

  always_comb begin
    colBits  = 5'd8 + {3'd0, cfgColSel};
    rowBits  = 5'd11 + {3'd0, cfgRowSel};
    bankBits = cfgFourBanks ? 5'd2 : 5'd1;
    wordAddr = latAddr >> cfgWidth;
    colSel   = COL_W'(wordAddr) & ((COL_W'(1) << colBits) - COL_W'(1));
    rowSel   = ROW_W'(wordAddr >> colBits) & ((ROW_W'(1) << rowBits) - ROW_W'(1));
    bankSel  = BANK_W'(wordAddr >> (colBits + rowBits)) &
               (cfgFourBanks ? BANK_W'(3) : BANK_W'(1));
    upper    = wordAddr >> (colBits + rowBits + bankBits);
    badCfg   = (cfgWidth == 2'd3) || (cfgRowSel == 2'd3);
    reqErr   = badCfg || (upper != '0) || (latWrite && cfgWrProt[latDev]);
    isWrite  = latWrite;
    devSel   = latDev;
  end

  // open-row record, one entry per device and bank
  logic             vld    [ENTRIES];
  logic [ROW_W-1:0] rowTab [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam int unsigned DEV_I  = e / BANK_MAX;
    localparam int unsigned BANK_I = e % BANK_MAX;
    logic sel;
    assign sel = (latDev == 1'(DEV_I)) && (bankSel == BANK_W'(BANK_I));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld[e]    <= 1'b0;
        rowTab[e] <= '0;
      end else if (strobe.clearAll) begin
        vld[e] <= 1'b0;
      end else if (sel && strobe.markOpen) begin
        vld[e]    <= 1'b1;
        rowTab[e] <= rowSel;
      end else if (sel && strobe.markClosed) begin
        vld[e] <= 1'b0;
      end
    end
  end

  logic [IDX_W-1:0] idx;
  assign idx      = {latDev, bankSel};
  assign bankOpen = vld[idx];
  assign hit      = bankOpen && (rowTab[idx] == rowSel);

  // address line drive; auto-precharge line stays low on accesses
  logic [ROW_W-1:0] colOut;
  always_comb begin
    colOut                  = '0;
    colOut[AP_BIT-1:0]      = colSel[AP_BIT-1:0];
    colOut[AP_BIT+1]        = colSel[AP_BIT];
    case (cmdCode)
      CMD_ACT:         cmdAddr = rowSel;
      CMD_RD, CMD_WR:  cmdAddr = colOut;
      CMD_PALL:        cmdAddr = ROW_W'(1) << AP_BIT;
      default:         cmdAddr = '0;
    endcase
  end
endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import rts_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pallReq,
  input  logic             reqValid,
  input  logic             isWrite,
  input  logic             hit,
  input  logic             bankOpen,
  input  logic             reqErr,
  input  logic [GAP_W-1:0] cfgTrp,
  input  logic [GAP_W-1:0] cfgTrcd,
  output strobe_t          strobe,
  output logic             reqReady,
  output logic             respValid,
  output logic             respErr,
  output logic             cmdValid,
  output cmd_e             cmdCode
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT_ACT, S_WAIT_RW} state_e;

  state_e           state, stateNext;
  logic [GAP_W-1:0] cnt, cntNext;
  cmd_e             rwCode;

  function automatic logic [GAP_W-1:0] gapLoad(input logic [GAP_W-1:0] g);
    return (g == '0) ? '0 : g - GAP_W'(1);
  endfunction

  assign rwCode = isWrite ? CMD_WR : CMD_RD;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobe    = '0;
    reqReady  = 1'b0;
    respValid = 1'b0;
    respErr   = 1'b0;
    cmdValid  = 1'b0;
    cmdCode   = CMD_NOP;
    case (state)
      S_IDLE: begin
        reqReady = !pallReq;
        if (pallReq) begin
          cmdValid        = 1'b1;
          cmdCode         = CMD_PALL;
          strobe.clearAll = 1'b1;
        end else if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext       = S_CHECK;
        end
      end
      S_CHECK: begin
        if (reqErr) begin
          respValid = 1'b1;
          respErr   = 1'b1;
          stateNext = S_IDLE;
        end else if (hit) begin
          cmdValid  = 1'b1;
          cmdCode   = rwCode;
          respValid = 1'b1;
          stateNext = S_IDLE;
        end else if (bankOpen) begin
          cmdValid          = 1'b1;
          cmdCode           = CMD_PRE;
          strobe.markClosed = 1'b1;
          cntNext           = gapLoad(cfgTrp);
          stateNext         = S_WAIT_ACT;
        end else begin
          cmdValid        = 1'b1;
          cmdCode         = CMD_ACT;
          strobe.markOpen = 1'b1;
          cntNext         = gapLoad(cfgTrcd);
          stateNext       = S_WAIT_RW;
        end
      end
      S_WAIT_ACT: begin
        if (cnt == '0) begin
          cmdValid        = 1'b1;
          cmdCode         = CMD_ACT;
          strobe.markOpen = 1'b1;
          cntNext         = gapLoad(cfgTrcd);
          stateNext       = S_WAIT_RW;
        end else begin
          cntNext = cnt - GAP_W'(1);
        end
      end
      S_WAIT_RW: begin
        if (cnt == '0) begin
          cmdValid  = 1'b1;
          cmdCode   = rwCode;
          respValid = 1'b1;
          stateNext = S_IDLE;
        end else begin
          cntNext = cnt - GAP_W'(1);
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end
endmodule

// File: rtl/row_track_seq.sv
module row_track_seq
  import rts_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgWidth,
  input  logic [1:0]         cfgRowSel,
  input  logic [1:0]         cfgColSel,
  input  logic               cfgFourBanks,
  input  logic [DEV_N-1:0]   cfgWrProt,
  input  logic [GAP_W-1:0]   cfgTrp,
  input  logic [GAP_W-1:0]   cfgTrcd,
  input  logic               pallReq,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [HADDR_W-1:0] reqAddr,
  output logic               reqReady,
  output logic               respValid,
  output logic               respErr,
  output logic               cmdValid,
  output logic [2:0]         cmdCode,
  output logic               cmdDev,
  output logic [BANK_W-1:0]  cmdBank,
  output logic [ROW_W-1:0]   cmdAddr
);
  strobe_t strobe;
  cmd_e    cmdCodeInt;
  logic    hit, bankOpen, reqErr, isWrite;

  rts_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWidth(cfgWidth), .cfgRowSel(cfgRowSel), .cfgColSel(cfgColSel),
    .cfgFourBanks(cfgFourBanks), .cfgWrProt(cfgWrProt),
    .strobe(strobe), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .cmdCode(cmdCodeInt),
    .hit(hit), .bankOpen(bankOpen), .reqErr(reqErr), .isWrite(isWrite),
    .devSel(cmdDev), .bankSel(cmdBank), .cmdAddr(cmdAddr)
  );

  rts_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pallReq(pallReq), .reqValid(reqValid),
    .isWrite(isWrite), .hit(hit), .bankOpen(bankOpen), .reqErr(reqErr),
    .cfgTrp(cfgTrp), .cfgTrcd(cfgTrcd),
    .strobe(strobe), .reqReady(reqReady), .respValid(respValid),
    .respErr(respErr), .cmdValid(cmdValid), .cmdCode(cmdCodeInt)
  );

  assign cmdCode = cmdCodeInt;
endmodule

// File: rtl/row_track_seq_chk.sv
module row_track_seq_chk
  import rts_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         cfgWidth,
  input logic [1:0]         cfgRowSel,
  input logic [1:0]         cfgColSel,
  input logic               cfgFourBanks,
  input logic [DEV_N-1:0]   cfgWrProt,
  input logic [GAP_W-1:0]   cfgTrp,
  input logic [GAP_W-1:0]   cfgTrcd,
  input logic               pallReq,
  input logic               reqValid,
  input logic               reqWrite,
  input logic [HADDR_W-1:0] reqAddr,
  input logic               reqReady,
  input logic               respValid,
  input logic               respErr,
  input logic               cmdValid,
  input logic [2:0]         cmdCode,
  input logic               cmdDev,
  input logic [BANK_W-1:0]  cmdBank,
  input logic [ROW_W-1:0]   cmdAddr
);
  logic isAccess;
  assign isAccess = cmdValid && ((cmdCode == 3'(CMD_RD)) || (cmdCode == 3'(CMD_WR)));

  // R12
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R9
  err_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respErr |-> !cmdValid);

  // R8
  rw_a10_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    isAccess |-> !cmdAddr[AP_BIT]);

  // R4
  resp_with_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respErr |-> isAccess);

  // R7
  pre_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdCode == 3'(CMD_PRE)) |=> !isAccess);

  // R11
  pall_a10_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdCode == 3'(CMD_PALL)) |-> cmdAddr[AP_BIT] && !reqReady);
endmodule

bind row_track_seq row_track_seq_chk u_chk (.*);

// File: tb/row_track_seq_tb.sv
`timescale 1ns/1ps
module row_track_seq_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cfgWidth, cfgRowSel, cfgColSel;
  logic        cfgFourBanks;
  logic [1:0]  cfgWrProt;
  logic [3:0]  cfgTrp, cfgTrcd;
  logic        pallReq, reqValid, reqWrite;
  logic [28:0] reqAddr;
  logic        reqReady, respValid, respErr, cmdValid, cmdDev;
  logic [2:0]  cmdCode;
  logic [1:0]  cmdBank;
  logic [12:0] cmdAddr;

  always #4 clk = ~clk;

  row_track_seq u_dut (.*);

  int nChecks = 0;
  int nFails  = 0;
  bit mVld [2][4];
  int mRow [2][4];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint packOut(bit rv, bit re, bit v, int code, int dev, int bank, int addr);
    return (longint'(rv) << 22) | (longint'(re) << 21) | (longint'(v) << 20) |
           (longint'(code & 7) << 16) | (longint'(dev & 1) << 15) |
           (longint'(bank & 3) << 13) | longint'(addr & 13'h1fff);
  endfunction

  function automatic longint actOut();
    return packOut(respValid, respErr, cmdValid, int'(cmdCode), int'(cmdDev),
                   int'(cmdBank), int'(cmdAddr));
  endfunction

  task automatic expCmd(input string tag, input int code, input int dev, input int bank,
                        input int addr, input bit resp);
    longint e;
    e = packOut(resp, 1'b0, 1'b1, code, dev, bank, addr);
    check(actOut() == e, tag, actOut(), e);
  endtask

  function automatic int cbits(); return 8 + int'(cfgColSel); endfunction
  function automatic int rbits(); return 11 + int'(cfgRowSel); endfunction
  function automatic int bbits(); return cfgFourBanks ? 2 : 1; endfunction

  function automatic logic [28:0] mkAddr(int dev, int bank, int row, int col);
    longint w;
    w = (longint'(bank) << (cbits() + rbits())) | (longint'(row) << cbits()) | longint'(col);
    return 29'((w << cfgWidth) | (longint'(dev) << 28));
  endfunction

  function automatic void decode(input logic [28:0] a, output int dev, output int bank,
                                 output int row, output int col, output bit err);
    longint w;
    w    = longint'(a[27:0]) / (longint'(1) << cfgWidth);
    col  = int'(w % (longint'(1) << cbits()));
    row  = int'((w / (longint'(1) << cbits())) % (longint'(1) << rbits()));
    bank = int'((w / (longint'(1) << (cbits() + rbits()))) % (cfgFourBanks ? 4 : 2));
    err  = (w / (longint'(1) << (cbits() + rbits() + bbits()))) != 0;
    dev  = int'(a[28]);
  endfunction

  function automatic int colPins(int col);
    return (col & 1023) | (((col >> 10) & 1) << 11);
  endfunction

  task automatic waitReady();
    @(negedge clk);
    for (int g = 0; g < 100 && !reqReady; g++) @(negedge clk);
  endtask

  task automatic gapWait(input int g, input string ctx);
    for (int i = 1; i < ((g < 1) ? 1 : g); i++) begin
      @(negedge clk);
      check(!cmdValid && !respValid, {ctx, " R7 gap quiet"},
            {cmdValid, respValid}, 0);
    end
    @(negedge clk);
  endtask

  task automatic doReq(input bit wr, input logic [28:0] addr, input string ctx);
    int dev, bank, row, col, code;
    bit err;
    decode(addr, dev, bank, row, col, err);
    if (wr && cfgWrProt[dev]) err = 1'b1;
    code = wr ? 3 : 2;
    waitReady();
    reqWrite = wr;
    reqAddr  = addr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (err) begin
      check(respValid && respErr && !cmdValid, {ctx, " R9 error no command"},
            actOut(), packOut(1'b1, 1'b1, 1'b0, 0, 0, 0, 0));
    end else if (mVld[dev][bank] && mRow[dev][bank] == row) begin
      expCmd({ctx, " R4 hit access"}, code, dev, bank, colPins(col), 1'b1);
    end else begin
      if (mVld[dev][bank]) begin
        expCmd({ctx, " R5 precharge"}, 4, dev, bank, 0, 1'b0);
        mVld[dev][bank] = 1'b0;
        gapWait(int'(cfgTrp), ctx);
        expCmd({ctx, " R5 R7 activate"}, 1, dev, bank, row, 1'b0);
      end else begin
        expCmd({ctx, " R6 activate"}, 1, dev, bank, row, 1'b0);
      end
      mVld[dev][bank] = 1'b1;
      mRow[dev][bank] = row;
      gapWait(int'(cfgTrcd), ctx);
      expCmd({ctx, " R7 access"}, code, dev, bank, colPins(col), 1'b1);
    end
  endtask

  task automatic doPall(input string ctx);
    waitReady();
    pallReq = 1'b1;
    #1;
    check(cmdValid && cmdCode == 3'd5 && cmdAddr[10] && !reqReady,
          {ctx, " R11 precharge-all strobe"},
          {cmdValid, cmdCode, cmdAddr[10], reqReady}, {1'b1, 3'd5, 1'b1, 1'b0});
    @(negedge clk);
    pallReq = 1'b0;
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 4; b++) mVld[d][b] = 1'b0;
  endtask

  task automatic setCfg(int w, int r, int c, bit fb, int trp, int trcd);
    cfgWidth = 2'(w); cfgRowSel = 2'(r); cfgColSel = 2'(c);
    cfgFourBanks = fb; cfgTrp = 4'(trp); cfgTrcd = 4'(trcd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [28:0] a;
    void'($urandom(32'd1234));
    rstN = 1'b0; pallReq = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0;
    cfgWrProt = 2'b00;
    setCfg(1, 1, 0, 1'b1, 2, 3);
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 4; b++) begin mVld[d][b] = 1'b0; mRow[d][b] = 0; end
    repeat (3) @(negedge clk);
    check(reqReady && !cmdValid && !respValid, "R12 reset state",
          {reqReady, cmdValid, respValid}, 3'b100);
    rstN = 1'b1;

    doReq(1'b0, mkAddr(0, 0, 5, 3), "R6 idle bank");
    doReq(1'b0, mkAddr(0, 0, 5, 7), "R4 same row");
    doReq(1'b0, mkAddr(0, 0, 5, 7) | 29'd1, "R1 byte bit ignored");
    doReq(1'b1, mkAddr(0, 0, 6, 2), "R5 row conflict");
    doReq(1'b0, mkAddr(1, 0, 5, 3), "R3 other device");
    doReq(1'b0, mkAddr(0, 0, 6, 9), "R3 first device kept");

    cfgWrProt = 2'b10;
    doReq(1'b1, mkAddr(1, 0, 5, 3), "R9 protected write");
    doReq(1'b0, mkAddr(1, 0, 5, 4), "R9 protected read ok");
    cfgWrProt = 2'b00;
    doReq(1'b0, 29'h0200_0000, "R9 R2 beyond span");

    doReq(1'b0, mkAddr(0, 1, 9, 255), "R10 row end");
    doReq(1'b0, mkAddr(0, 1, 9, 255) + 29'd2, "R10 next row");
    doReq(1'b0, mkAddr(0, 1, 4095, 255) + 29'd2, "R10 next bank");
    cfgFourBanks = 1'b0;
    doReq(1'b0, mkAddr(0, 1, 4095, 255) + 29'd2, "R10 two-bank overrun");
    cfgFourBanks = 1'b1;

    setCfg(2, 2, 3, 1'b1, 0, 1);
    doReq(1'b0, mkAddr(0, 3, 8191, 2047), "R10 last bank");
    a = mkAddr(0, 3, 8191, 2047) + 29'd4;
    check(a == 29'h1000_0000, "R10 full span reaches device 1", a, 29'h1000_0000);
    doReq(1'b0, a, "R10 into second device");
    doReq(1'b1, mkAddr(0, 2, 1, 11'h5FF), "R8 column bit 10");
    doReq(1'b0, mkAddr(0, 2, 3, 4) | 29'd3, "R1 32-bit byte bits");

    setCfg(0, 0, 0, 1'b1, 3, 0);
    doReq(1'b0, 29'h0020_0000, "R2 past bank field");
    doReq(1'b0, 29'h001F_FFFF, "R2 top of span");
    doPall("R11");
    doReq(1'b0, 29'h001F_FFFF, "R11 reopen after precharge-all");

    for (int it = 0; it < 400; it++) begin
      int dev, bank, row, col, sh;
      bit wr;
      if (it % 25 == 0) begin
        setCfg(int'($urandom % 3), int'($urandom % 3), int'($urandom % 4),
               1'($urandom % 2), int'($urandom % 6), int'($urandom % 6));
        cfgWrProt = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'b00;
        if ($urandom % 2 == 0) doPall("R11 random");
      end
      dev  = int'($urandom % 2);
      bank = int'($urandom % (cfgFourBanks ? 4 : 2));
      row  = int'($urandom % 4);
      col  = int'($urandom % (1 << cbits()));
      wr   = 1'($urandom % 2);
      a    = mkAddr(dev, bank, row, col) | 29'($urandom % (1 << cfgWidth));
      sh   = cbits() + rbits() + bbits() + int'(cfgWidth);
      if ($urandom % 16 == 0 && sh < 28) a = a | (29'd1 << sh);
      doReq(wr, a, "random");
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule